// File: doc/BRIEF.md
# Dictionary Codeword Expander

This block turns a stream of fixed-width codewords back into the bit stream they stand for. Each codeword is an index into a small table held inside the block. A programmable entry holds a dataword and its length, and the block sends that dataword out one bit per output handshake, least significant bit first. Software fills the table through a write port that takes an index, a length and a dataword in a single cycle.

Three low indices are fixed in hardware and cannot be written. One sends a single 0 bit and one sends a single 1 bit, so any bit pattern can still be built from them. The third sends nothing and takes one cycle. Codewords arrive in groups called compressed sequences. The last codeword of a group is flagged on the input, and that flag comes out on the last output beat of the group. When the flagged codeword has no data bits, the block sends one extra beat that carries only the flag and is marked as holding no data.

The block accepts a new codeword only after every bit of the previous dataword has been sent. Expanding the codewords of a group in arrival order gives back the original stream exactly.

Top module: `dx_expander`

## Requirements
- R1: After reset `bit_valid` is 0 and `cw_ready` is 1, and every programmable entry (index 3 and above) has length 0, so it sends no data bits.
- R2: A codeword whose entry has length L (1 to 16) produces exactly L output beats carrying dataword bits 0 to L-1, bit 0 first. After the last of these beats `cw_ready` is 1 again.
- R3: Codeword 0 produces exactly one beat with `bit_data` = 0 and `bit_empty` = 0.
- R4: Codeword 1 produces exactly one beat with `bit_data` = 1 and `bit_empty` = 0.
- R5: Codeword 2 without the group-end flag produces no output beat. `cw_ready` stays 1 in the cycle after it is accepted.
- R6: Writes to indices 0, 1 and 2 are ignored. Those codewords keep the behaviour given in R3, R4 and R5.
- R7: `bit_last` is 1 only on the final beat of a codeword accepted with `cw_last` = 1. It is 0 on every other beat.
- R8: A codeword of length 0 (codeword 2, or an entry programmed to length 0) accepted with `cw_last` = 1 produces exactly one beat with `bit_last` = 1, `bit_empty` = 1 and `bit_data` = 0. Every beat that carries data has `bit_empty` = 0.
- R9: `cw_ready` is 0 while any output beat is pending. While `bit_valid` = 1 and `bit_ready` = 0, the outputs `bit_valid`, `bit_data`, `bit_last` and `bit_empty` hold their values into the next cycle.
- R10: When a write to an entry happens in the same cycle as that entry's codeword is accepted, the expansion uses the old contents. A codeword accepted later uses the new contents.
- R11: A written length above 16 is stored as 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 8 | Table index to write |
| cfg_len | input | 5 | Dataword length in bits |
| cfg_data | input | 16 | Dataword, bit 0 sent first |
| cw_valid | input | 1 | Codeword valid |
| cw_ready | output | 1 | Codeword accepted when both are high |
| cw_code | input | 8 | Codeword index |
| cw_last | input | 1 | Codeword ends a compressed sequence |
| bit_valid | output | 1 | Output beat valid |
| bit_ready | input | 1 | Output beat taken when both are high |
| bit_data | output | 1 | Restored data bit |
| bit_last | output | 1 | Final beat of a compressed sequence |
| bit_empty | output | 1 | Beat carries only the sequence-end flag |

## Verification
A wrong bit counter shows up straight away as a beat too many or too few for a codeword. It also shows as `cw_ready` rising early or late, inside the expansion of that same codeword. A corrupted shift register or table entry shows a wrong bit at the first affected beat position. A stale sequence-end flag shows as `bit_last` on the wrong beat, or a missing marker beat, within one codeword. The bench therefore checks every beat of every codeword against a table model kept in the bench, under random back-pressure, so that each such fault is caught at the first codeword that uses the broken state.

// File: rtl/dx_pkg.sv
package dx_pkg;
   // Hardwired codeword indices; these are decoded, never stored.
   localparam int unsigned RSV_ZERO  = 0;
   localparam int unsigned RSV_ONE   = 1;
   localparam int unsigned RSV_EMPTY = 2;
   localparam int unsigned NUM_RSV   = 3;
endpackage

// File: rtl/dx_dict.sv
module dx_dict
   import dx_pkg::*;
#(
   parameter int unsigned CW_W    = 8,
   parameter int unsigned ENTRIES = 256,
   parameter int unsigned MAX_LEN = 16,
   parameter int unsigned LEN_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [CW_W-1:0]    wr_idx,
   input  logic [LEN_W-1:0]   wr_len,
   input  logic [MAX_LEN-1:0] wr_data,
   input  logic [CW_W-1:0]    rd_idx,
   output logic [LEN_W-1:0]   rd_len,
   output logic [MAX_LEN-1:0] rd_data
);
   localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_LEN);
   localparam logic [CW_W:0]    ENT_LIM = (CW_W+1)'(ENTRIES);

   logic [LEN_W-1:0]   len_arr [ENTRIES];
   logic [MAX_LEN-1:0] dat_arr [ENTRIES];
   logic [LEN_W-1:0]   wr_len_c;

   assign wr_len_c = (wr_len > LEN_CAP) ? LEN_CAP : wr_len;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      if (g < NUM_RSV) begin : g_fixed
         assign len_arr[g] = (g == RSV_EMPTY) ? '0 : LEN_W'(1);
         assign dat_arr[g] = (g == RSV_ONE) ? MAX_LEN'(1) : '0;
      end else begin : g_prog
         logic [LEN_W-1:0]   len_q;
         logic [MAX_LEN-1:0] dat_q;
         logic               hit;
         assign hit = wr_en && (wr_idx == CW_W'(g));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   len_q <= '0;
            else if (hit) len_q <= wr_len_c;
         end
         always_ff @(posedge clk) begin
            if (hit) dat_q <= wr_data;
         end
         assign len_arr[g] = len_q;
         assign dat_arr[g] = dat_q;
      end
   end

   always_comb begin
      rd_len  = '0;
      rd_data = '0;
      if ({1'b0, rd_idx} < ENT_LIM) begin
         rd_len  = len_arr[rd_idx];
         rd_data = dat_arr[rd_idx];
      end
   end
endmodule

// File: rtl/dx_emit.sv
module dx_emit #(
   parameter int unsigned MAX_LEN = 16,
   parameter int unsigned LEN_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [LEN_W-1:0]   ld_len,
   input  logic [MAX_LEN-1:0] ld_data,
   input  logic               ld_last,
   input  logic               out_ready,
   output logic               out_valid,
   output logic               out_bit,
   output logic               out_last,
   output logic               out_empty,
   output logic               idle
);
   logic [MAX_LEN-1:0] sh_q;
   logic [LEN_W-1:0]   cnt_q;
   logic               last_q;
   logic               mark_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         cnt_q  <= '0;
         last_q <= 1'b0;
         mark_q <= 1'b0;
      end else if (load) begin
         sh_q   <= ld_data;
         cnt_q  <= ld_len;
         last_q <= ld_last;
         mark_q <= (ld_len == '0) && ld_last;
      end else if (out_valid && out_ready) begin
         if (mark_q) begin
            mark_q <= 1'b0;
         end else begin
            sh_q  <= sh_q >> 1;
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign out_valid = (cnt_q != '0) || mark_q;
   assign out_bit   = mark_q ? 1'b0 : sh_q[0];
   assign out_last  = mark_q || ((cnt_q == LEN_W'(1)) && last_q);
   assign out_empty = mark_q;
   assign idle      = !out_valid;
endmodule

// File: rtl/dx_expander.sv
module dx_expander
   import dx_pkg::*;
#(
   parameter int unsigned CW_W    = 8,
   parameter int unsigned ENTRIES = 256,
   parameter int unsigned MAX_LEN = 16,
   parameter int unsigned LEN_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [CW_W-1:0]    cfg_idx,
   input  logic [LEN_W-1:0]   cfg_len,
   input  logic [MAX_LEN-1:0] cfg_data,
   input  logic               cw_valid,
   output logic               cw_ready,
   input  logic [CW_W-1:0]    cw_code,
   input  logic               cw_last,
   output logic               bit_valid,
   input  logic               bit_ready,
   output logic               bit_data,
   output logic               bit_last,
   output logic               bit_empty
);
   if (MAX_LEN >= (1 << LEN_W)) begin : g_bad_len
      $error("dx_expander: LEN_W too narrow for MAX_LEN");
   end
   if (ENTRIES > (1 << CW_W)) begin : g_bad_depth
      $error("dx_expander: ENTRIES exceeds codeword space");
   end
   if (ENTRIES <= NUM_RSV) begin : g_bad_rsv
      $error("dx_expander: no room for programmable entries");
   end

   logic [LEN_W-1:0]   lk_len;
   logic [MAX_LEN-1:0] lk_data;
   logic               idle;
   logic               take;

   assign cw_ready = idle;
   assign take     = cw_valid && idle;

   dx_dict #(
      .CW_W(CW_W), .ENTRIES(ENTRIES), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)
   ) u_dict (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_len(cfg_len), .wr_data(cfg_data),
      .rd_idx(cw_code), .rd_len(lk_len), .rd_data(lk_data)
   );

   dx_emit #(
      .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)
   ) u_emit (
      .clk(clk), .rst_n(rst_n),
      .load(take), .ld_len(lk_len), .ld_data(lk_data), .ld_last(cw_last),
      .out_ready(bit_ready), .out_valid(bit_valid), .out_bit(bit_data),
      .out_last(bit_last), .out_empty(bit_empty), .idle(idle)
   );
endmodule

// File: rtl/dx_checker.sv
module dx_checker #(
   parameter int unsigned CW_W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cw_valid,
   input logic            cw_ready,
   input logic [CW_W-1:0] cw_code,
   input logic            cw_last,
   input logic            bit_valid,
   input logic            bit_ready,
   input logic            bit_data,
   input logic            bit_last,
   input logic            bit_empty
);
   logic fire;
   assign fire = cw_valid && cw_ready;

   a_r1_reset_idle: assert property (@(posedge clk)
      !rst_n |=> !bit_valid && cw_ready);

   a_r3_inject_zero: assert property (@(posedge clk) disable iff (!rst_n)
      fire && cw_code == CW_W'(0) |=> bit_valid && !bit_data && !bit_empty);

   a_r4_inject_one: assert property (@(posedge clk) disable iff (!rst_n)
      fire && cw_code == CW_W'(1) |=> bit_valid && bit_data && !bit_empty);

   a_r5_empty_skip: assert property (@(posedge clk) disable iff (!rst_n)
      fire && cw_code == CW_W'(2) && !cw_last |=> !bit_valid && cw_ready);

   a_r7_no_early_last: assert property (@(posedge clk) disable iff (!rst_n)
      fire && cw_code == CW_W'(1) && !cw_last |=> !bit_last);

   a_r8_marker_beat: assert property (@(posedge clk) disable iff (!rst_n)
      fire && cw_code == CW_W'(2) && cw_last |=> bit_valid && bit_last && bit_empty && !bit_data);

   a_r9_busy_block: assert property (@(posedge clk) disable iff (!rst_n)
      bit_valid |-> !cw_ready);

   a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      bit_valid && !bit_ready |=> bit_valid && $stable(bit_data) && $stable(bit_last) && $stable(bit_empty));
endmodule

bind dx_expander dx_checker #(.CW_W(CW_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .cw_valid(cw_valid), .cw_ready(cw_ready), .cw_code(cw_code), .cw_last(cw_last),
   .bit_valid(bit_valid), .bit_ready(bit_ready), .bit_data(bit_data),
   .bit_last(bit_last), .bit_empty(bit_empty)
);

// File: tb/dx_expander_bench.sv
`timescale 1ns/1ps
module dx_expander_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_idx = '0;
   logic [4:0]  cfg_len = '0;
   logic [15:0] cfg_data = '0;
   logic        cw_valid = 1'b0;
   logic        cw_ready;
   logic [7:0]  cw_code = '0;
   logic        cw_last = 1'b0;
   logic        bit_valid;
   logic        bit_ready = 1'b0;
   logic        bit_data;
   logic        bit_last;
   logic        bit_empty;

   int checks = 0;
   int failures = 0;
   int          ref_len  [256];
   logic [15:0] ref_data [256];

   always #5 clk = ~clk;

   dx_expander u_dx_expander (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_len(cfg_len), .cfg_data(cfg_data),
      .cw_valid(cw_valid), .cw_ready(cw_ready), .cw_code(cw_code), .cw_last(cw_last),
      .bit_valid(bit_valid), .bit_ready(bit_ready), .bit_data(bit_data),
      .bit_last(bit_last), .bit_empty(bit_empty)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic void model_write(input int idx, input int len, input logic [15:0] d);
      if (idx > 2) begin
         ref_len[idx]  = (len > 16) ? 16 : len;
         ref_data[idx] = d;
      end
   endfunction

   function automatic void model_get(input int c, output int l, output logic [15:0] d);
      if (c == 0)      begin l = 1; d = 16'h0; end
      else if (c == 1) begin l = 1; d = 16'h1; end
      else if (c == 2) begin l = 0; d = 16'h0; end
      else             begin l = ref_len[c]; d = ref_data[c]; end
   endfunction

   task automatic cfg_write(input int idx, input int len, input logic [15:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 8'(idx); cfg_len = 5'(len); cfg_data = d;
      @(negedge clk);
      cfg_we = 1'b0;
      model_write(idx, len, d);
   endtask

   // Send one codeword (optionally with a same-cycle table write) and check every beat.
   task automatic run_code(input int code, input bit last, input bit do_wr,
                           input int wlen, input logic [15:0] wdata,
                           input bit stall, input string req);
      int exp_len;
      logic [15:0] exp_d;
      int beats;
      int got = 0;
      int guard = 0;
      bit bad = 0;
      bit held = 0;
      logic hb, hl, he;
      logic [31:0] act_v = 0;
      logic [31:0] exp_v = 0;
      model_get(code, exp_len, exp_d);
      beats = (exp_len == 0) ? (last ? 1 : 0) : exp_len;
      @(negedge clk);
      cw_valid = 1'b1; cw_code = 8'(code); cw_last = last;
      if (do_wr) begin
         cfg_we = 1'b1; cfg_idx = 8'(code); cfg_len = 5'(wlen); cfg_data = wdata;
      end
      @(negedge clk);
      cw_valid = 1'b0; cfg_we = 1'b0;
      if (do_wr) model_write(code, wlen, wdata);
      if (beats == 0) begin
         check(!bit_valid && cw_ready, req, "empty codeword outputs valid/ready",
               {bit_valid, cw_ready}, 2'b01);
         return;
      end
      while (got < beats && guard < 400) begin
         logic r;
         if (held) begin
            check(bit_valid && bit_data == hb && bit_last == hl && bit_empty == he,
                  "R9", "stalled beat changed", {bit_valid, bit_data, bit_last, bit_empty},
                  {1'b1, hb, hl, he});
            held = 0;
         end
         if (bit_valid && cw_ready) bad = 1;
         r = stall ? (guard % 3 == 2) : ($urandom % 4 != 0);
         bit_ready = r;
         if (bit_valid && r) begin
            logic eb, el, ee;
            if (exp_len == 0) begin eb = 0; el = 1; ee = 1; end
            else begin eb = exp_d[got]; el = last && (got == exp_len - 1); ee = 0; end
            if (bit_data !== eb || bit_last !== el || bit_empty !== ee) begin
               bad = 1;
               act_v = {got[15:0], 5'b0, bit_data, bit_last, bit_empty};
               exp_v = {got[15:0], 5'b0, eb, el, ee};
            end
            got++;
         end else if (bit_valid) begin
            held = 1; hb = bit_data; hl = bit_last; he = bit_empty;
         end
         @(negedge clk);
         guard++;
      end
      bit_ready = 1'b0;
      check(!bad, req, "beat content {idx,bit,last,empty}", act_v, exp_v);
      check(got == beats && !bit_valid && cw_ready, req, "beat count / ready after codeword",
            32'(got), 32'(beats));
   endtask

   initial begin
      int wd_cycles = 0;
      while (wd_cycles < 150000) begin
         @(posedge clk);
         wd_cycles++;
      end
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", wd_cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      for (int i = 0; i < 256; i++) begin ref_len[i] = 0; ref_data[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state and empty programmable entries
      check(!bit_valid && cw_ready, "R1", "reset outputs", {bit_valid, cw_ready}, 2'b01);
      run_code(50, 0, 0, 0, 0, 0, "R1");
      run_code(200, 1, 0, 0, 0, 0, "R1");
      // R3 / R4 / R7: single-bit injections
      run_code(0, 0, 0, 0, 0, 0, "R3");
      run_code(1, 1, 0, 0, 0, 0, "R4");
      run_code(1, 0, 0, 0, 0, 0, "R7");
      // R5 / R8: empty codeword
      run_code(2, 0, 0, 0, 0, 0, "R5");
      run_code(2, 1, 0, 0, 0, 0, "R8");
      // R2: programmed entries of several lengths
      cfg_write(10, 16, 16'hA5C3);
      cfg_write(11, 1, 16'hFFFF);
      cfg_write(12, 7, 16'h0055);
      run_code(10, 0, 0, 0, 0, 0, "R2");
      run_code(11, 1, 0, 0, 0, 0, "R2");
      run_code(12, 1, 0, 0, 0, 0, "R7");
      // R11: length clamp
      cfg_write(13, 31, 16'h9E37);
      run_code(13, 1, 0, 0, 0, 0, "R11");
      // R6: writes to reserved indices have no effect
      cfg_write(0, 5, 16'hFFFF);
      cfg_write(1, 9, 16'h0000);
      cfg_write(2, 4, 16'h000F);
      run_code(0, 1, 0, 0, 0, 0, "R6");
      run_code(1, 0, 0, 0, 0, 0, "R6");
      run_code(2, 0, 0, 0, 0, 0, "R6");
      // R8: programmed zero-length entry ending a sequence
      cfg_write(14, 0, 16'h1234);
      run_code(14, 1, 0, 0, 0, 0, "R8");
      // R9: heavy back-pressure
      run_code(10, 1, 0, 0, 0, 1, "R9");
      // R10: write in the same cycle as lookup, then the new contents
      run_code(10, 0, 1, 3, 16'h0005, 0, "R10");
      run_code(10, 1, 0, 0, 0, 0, "R10");
      // Random table and codeword mix
      for (int i = 0; i < 40; i++)
         cfg_write($urandom_range(0, 255), $urandom_range(0, 20), 16'($urandom));
      for (int i = 0; i < 300; i++) begin
         int c = $urandom_range(0, 255);
         bit l = ($urandom % 4 == 0);
         bit w = ($urandom % 10 == 0);
         run_code(c, l, w, $urandom_range(0, 20), 16'($urandom), 0, "R2");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule